// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between a host processor and an eight-register, byte-wide peripheral register file. A strap input, fixed after reset, selects one of two host bus protocols on the same set of pins. In split-strobe mode the host uses separate active-low read and write strobes. In combined mode the write-strobe pin acts as a direction line (1 read, 0 write), qualified by chip select, and the read-strobe pin is ignored.

All host inputs cross into the system clock through a two-stage synchronizer. The block detects the start and end of each access and turns each access into exactly one single-cycle internal read or write pulse. It decodes the 3-bit address into a one-hot register select and opens the data bus output enable for the whole read. The interrupt pin follows the selected protocol. In split-strobe mode it is an active-high output that a control bit can float. In combined mode it is an active-low open-drain pull-down.

Top module: `hbi_top`

## Requirements
- R1: `bus_mode`=1 selects split strobes (`rd_n`, `wr_n`). `bus_mode`=0 selects combined mode, where `wr_n` is a direction line (1 read, 0 write) and `rd_n` has no effect.
- R2: While `cs_n` is high, no strobe or direction activity produces `reg_rd`, `reg_wr` or `data_oe`.
- R3: Each read access produces exactly one `reg_rd` pulse, one cycle wide. `reg_sel` is one-hot, with bit n set for address n, and `reg_sel` is set to the read address while the read lasts.
- R4: Each write access produces exactly one `reg_wr` pulse, one cycle wide, at the end of the access. In split mode the end is when `wr_n` rises. In combined mode the end is when `cs_n` rises. During the pulse, `reg_wdata` holds the last data byte seen during the access, and `reg_sel` selects the write address.
- R5: `data_oe` is 1 only while a read access is active. While it is 1, `data_out` equals `reg_rdata`. A read returns the byte last written to that address.
- R6: In split mode, `irq_out` equals `irq_pending` (active high), and `irq_oe` equals `irq_en`. When `irq_en` is 0, the pin floats.
- R7: In combined mode, `irq_out` is 0 and `irq_oe` equals `irq_pending`, which gives an open-drain pull-down. `irq_en` has no effect.
- R8: A bus input change is first visible at the outputs after the third rising clock edge. This is two synchronizer stages plus one register.
- R9: After reset, `data_oe`, `reg_rd` and `reg_wr` are 0, and `reg_sel` is 8'b0000_0001.
- R10: In split mode, if both strobes are low with `cs_n` low, no access is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Protocol strap: 1 split strobes, 0 combined direction |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low (split mode only) |
| wr_n | input | 1 | Write strobe (split) or direction, 1 read / 0 write (combined) |
| addr | input | 3 | Register address |
| data_in | input | 8 | Data bus, host to block |
| data_out | output | 8 | Data bus, block to host |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| irq_en | input | 1 | Interrupt output enable control bit |
| irq_pending | input | 1 | Interrupt request from the register file |
| irq_out | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive enable; 0 means high impedance |
| reg_sel | output | 8 | One-hot register select |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for the selected register |

## Verification
Every address in both protocols is first written with a byte computed from the address and the mode, then read back. This separates address decode faults from data capture faults, and it also exposes any mix-up in the mode multiplexing. In combined mode `rd_n` is held low throughout, so any leak of that pin shows up as a spurious read. Accesses with chip select high and with both strobes low must leave the pulse counts and the register contents unchanged. A step test pins the latency to the third edge. The interrupt pin is swept over all eight combinations of mode, enable and pending, which shows the float cases apart from the driven ones.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;

    typedef enum logic {
        MODE_COMBINED = 1'b0,
        MODE_SPLIT    = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic              cs_n;
        logic              rd_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_sample_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } access_t;

    localparam bus_sample_t SAMPLE_IDLE = '{
        cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0
    };

    function automatic logic [NREG-1:0] addr_to_sel(input logic [ADDR_W-1:0] a);
        logic [NREG-1:0] s;
        s = '0;
        s[a] = 1'b1;
        return s;
    endfunction

    // Which access kind the present pin levels describe.
    function automatic access_t classify(input bus_mode_e m, input logic cs_n,
                                         input logic rd_n, input logic wr_n);
        access_t r;
        r = '0;
        if (!cs_n) begin
            if (m == MODE_SPLIT) begin
                r.rd = !rd_n && wr_n;
                r.wr = !wr_n && rd_n;
            end else begin
                r.rd = wr_n;
                r.wr = !wr_n;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[g] <= RST_VAL;
                end else begin
                    if (g == 0) stage[g] <= d;
                    else        stage[g] <= stage[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/hbi_cycle_ctl.sv
module hbi_cycle_ctl
    import hbi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_mode_e           mode,
    input  bus_sample_t         smp,
    output logic                reg_rd,
    output logic                reg_wr,
    output logic [NREG-1:0]     reg_sel,
    output logic [DATA_W-1:0]   reg_wdata,
    output logic                data_oe
);

    access_t           act, act_q;
    logic              rd_start, wr_start, wr_end;
    logic              rd_q, wr_q, oe_q;
    logic [ADDR_W-1:0] raddr_q, waddr_q;
    logic [DATA_W-1:0] wdata_q;

    always_comb begin
        act      = classify(mode, smp.cs_n, smp.rd_n, smp.wr_n);
        rd_start = act.rd && !act_q.rd;
        wr_start = act.wr && !act_q.wr;
        wr_end   = act_q.wr && !act.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            oe_q    <= 1'b0;
            raddr_q <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            act_q <= act;
            rd_q  <= rd_start;
            wr_q  <= wr_end;
            oe_q  <= act.rd;
            if (rd_start) raddr_q <= smp.addr;
            if (wr_start) waddr_q <= smp.addr;
            if (act.wr)   wdata_q <= smp.data;
        end
    end

    assign reg_rd    = rd_q;
    assign reg_wr    = wr_q;
    assign data_oe   = oe_q;
    assign reg_wdata = wdata_q;
    assign reg_sel   = addr_to_sel(wr_q ? waddr_q : raddr_q);

endmodule

// File: rtl/hbi_irq_drive.sv
module hbi_irq_drive
    import hbi_pkg::*;
(
    input  bus_mode_e mode,
    input  logic      irq_en,
    input  logic      irq_pending,
    output logic      irq_out,
    output logic      irq_oe
);

    always_comb begin
        unique case (mode)
            MODE_SPLIT: begin
                irq_out = irq_pending;
                irq_oe  = irq_en;
            end
            default: begin
                irq_out = 1'b0;
                irq_oe  = irq_pending;
            end
        endcase
    end

endmodule

// File: rtl/hbi_top.sv
module hbi_top
    import hbi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              irq_en,
    input  logic              irq_pending,
    output logic              irq_out,
    output logic              irq_oe,
    output logic [NREG-1:0]   reg_sel,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int SAMPLE_W = $bits(bus_sample_t);

    bus_mode_e   mode;
    bus_sample_t raw, smp;

    assign mode = bus_mode_e'(bus_mode);
    assign raw  = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, addr: addr, data: data_in};

    hbi_sync #(
        .W       (SAMPLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SAMPLE_IDLE)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (smp)
    );

    hbi_cycle_ctl i_ctl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .smp       (smp),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .data_oe   (data_oe)
    );

    hbi_irq_drive i_irq (
        .mode        (mode),
        .irq_en      (irq_en),
        .irq_pending (irq_pending),
        .irq_out     (irq_out),
        .irq_oe      (irq_oe)
    );

    assign data_out = reg_rdata;

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_mode,
    input logic       irq_en,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic       data_oe,
    input logic       irq_out,
    input logic       irq_oe,
    input logic [7:0] reg_sel
);

    assert_rd_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(reg_sel) == 1);

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    assert_oe_opens_with_read_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> reg_rd);

    assert_no_read_on_close_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(data_oe) |-> !reg_rd);

    assert_float_when_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_mode && !irq_en) |-> !irq_oe);

    assert_open_drain_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && irq_oe) |-> !irq_out);

endmodule

bind hbi_top hbi_checker i_hbi_checker (
    .clk      (clk),
    .rst      (rst),
    .bus_mode (bus_mode),
    .irq_en   (irq_en),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .data_oe  (data_oe),
    .irq_out  (irq_out),
    .irq_oe   (irq_oe),
    .reg_sel  (reg_sel)
);

// File: tb/test_hbi_top.sv
`timescale 1ns/1ps
module test_hbi_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_mode = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic       irq_en = 1'b0, irq_pending = 1'b0;
    logic       irq_out, irq_oe;
    logic [7:0] reg_sel;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] regs     [8];
    logic [7:0] exp_regs [8];
    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0;

    always #2.5 clk = ~clk;

    hbi_top i_hbi_top (
        .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .irq_en(irq_en), .irq_pending(irq_pending),
        .irq_out(irq_out), .irq_oe(irq_oe), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int sel_idx(input logic [7:0] s);
        for (int i = 0; i < 8; i++) if (s[i]) return i;
        return 0;
    endfunction

    assign reg_rdata = regs[sel_idx(reg_sel)];

    initial for (int i = 0; i < 8; i++) begin regs[i] = '0; exp_regs[i] = '0; end

    always @(posedge clk) begin
        if (reg_rd) rd_cnt++;
        if (reg_wr) begin
            wr_cnt++;
            regs[sel_idx(reg_sel)] <= reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic m, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d;
        if (m) begin
            cs_n = 1'b0; repeat (2) @(negedge clk);
            wr_n = 1'b0; repeat (5) @(negedge clk);
            wr_n = 1'b1; repeat (2) @(negedge clk);
            cs_n = 1'b1;
        end else begin
            wr_n = 1'b0; @(negedge clk);
            cs_n = 1'b0; repeat (5) @(negedge clk);
            cs_n = 1'b1; repeat (2) @(negedge clk);
            wr_n = 1'b1;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_read(input logic m, input logic [2:0] a,
                            output logic [7:0] got, output logic oe);
        @(negedge clk); addr = a;
        if (m) begin
            cs_n = 1'b0; @(negedge clk);
            rd_n = 1'b0;
        end else begin
            wr_n = 1'b1; cs_n = 1'b0;
        end
        repeat (5) @(negedge clk);
        got = data_out; oe = data_oe;
        if (m) rd_n = 1'b1;
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got, val;
        logic       oe;
        int         r0, w0;

        repeat (4) @(negedge clk);
        check("R9 data_oe after reset", data_oe, 0);
        check("R9 reg_rd after reset", reg_rd, 0);
        check("R9 reg_wr after reset", reg_wr, 0);
        check("R9 reg_sel after reset", reg_sel, 8'h01);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R8: latency of a read start in split mode
        bus_mode = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0; addr = 3'd0;
        repeat (2) @(negedge clk);
        check("R8 oe not yet after two edges", data_oe, 0);
        @(negedge clk);
        check("R8 oe after third edge", data_oe, 1);
        check("R8 read pulse at third edge", reg_rd, 1);
        @(negedge clk);
        check("R3 read pulse one cycle", reg_rd, 0);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int mi = 1; mi >= 0; mi--) begin
            logic m;
            m = mi[0];
            bus_mode = m;
            rd_n = m ? 1'b1 : 1'b0;   // R1: combined mode keeps rd_n low throughout
            repeat (3) @(negedge clk);
            for (int a = 0; a < 8; a++) begin
                val = 8'(a * 29 + mi * 101 + 7);
                r0 = rd_cnt; w0 = wr_cnt;
                bus_write(m, 3'(a), val);
                exp_regs[a] = val;
                check(m ? "R4 split write pulse count" : "R4 combined write pulse count", wr_cnt - w0, 1);
                check(m ? "R1 split write no read" : "R1 combined rd_n ignored on write", rd_cnt - r0, 0);
            end
            for (int a = 0; a < 8; a++) begin
                r0 = rd_cnt; w0 = wr_cnt;
                bus_read(m, 3'(a), got, oe);
                check("R5 read data matches written byte", got, exp_regs[a]);
                check("R5 oe during read", oe, 1);
                check("R3 read pulse count", rd_cnt - r0, 1);
                check("R1 read makes no write", wr_cnt - w0, 0);
                check("R5 oe released after read", data_oe, 0);
            end
            check("R3 sel tracks last read address", reg_sel, 8'h80);
        end

        // R2: chip select high blocks all activity (split mode)
        bus_mode = 1'b1; rd_n = 1'b1;
        repeat (3) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        addr = 3'd3; data_in = 8'hEE;
        rd_n = 1'b0; repeat (5) @(negedge clk);
        check("R2 no oe with cs high", data_oe, 0);
        rd_n = 1'b1; wr_n = 1'b0; repeat (5) @(negedge clk);
        wr_n = 1'b1; repeat (5) @(negedge clk);
        check("R2 no pulses with cs high", (rd_cnt - r0) + (wr_cnt - w0), 0);
        bus_read(1'b1, 3'd3, got, oe);
        check("R2 register unchanged", got, exp_regs[3]);

        // R2 in combined mode: direction toggling with cs high
        bus_mode = 1'b0;
        repeat (3) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        wr_n = 1'b0; repeat (5) @(negedge clk);
        wr_n = 1'b1; repeat (5) @(negedge clk);
        check("R2 combined no pulses with cs high", (rd_cnt - r0) + (wr_cnt - w0), 0);

        // R10: both strobes low in split mode
        bus_mode = 1'b1;
        repeat (3) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        addr = 3'd5; data_in = 8'h5A;
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 no oe with both strobes low", data_oe, 0);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 no pulses with both strobes low", (rd_cnt - r0) + (wr_cnt - w0), 0);
        bus_read(1'b1, 3'd5, got, oe);
        check("R10 register unchanged", got, exp_regs[5]);

        // R6/R7: interrupt pin sweep
        for (int k = 0; k < 8; k++) begin
            bus_mode = k[2]; irq_en = k[1]; irq_pending = k[0];
            #1;
            if (k[2]) begin
                check("R6 split irq_oe", irq_oe, k[1]);
                check("R6 split irq_out", irq_out, k[0]);
            end else begin
                check("R7 combined irq_oe", irq_oe, k[0]);
                check("R7 combined irq_out", irq_out, 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule